// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake lines (clear-to-send, data-set-ready, ring indicator and carrier detect). It reports their asserted levels, together with four sticky change flags, in one 8-bit status word. The pins are first passed through a synchronizer. Edge detection then runs on the synchronized levels. Each change flag stays set until the host reads the status word.

A loopback control lets firmware test the status path without external wiring. While loopback is on, the four levels are taken from internal modem-control bits and not from the pins. The mapping crosses lines: the request-to-send bit feeds clear-to-send, the terminal-ready bit feeds data-set-ready, and two auxiliary bits feed ring and carrier. A modem status interrupt request is raised while any change flag is set and the interrupt enable is high.

Top module: `msd_modem_status`

## Requirements
- R1: With loopback off, status bits 7, 6, 5 and 4 read as the complement of the carrier, ring, data-set-ready and clear-to-send pins, in that order.
- R2: With loopback on, status bit 4 follows `lb_ctrl[1]` (request-to-send), bit 5 follows `lb_ctrl[0]` (terminal-ready), bit 6 follows `lb_ctrl[2]` and bit 7 follows `lb_ctrl[3]`. Pin activity does not change the status word in this mode.
- R3: Change flags at bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier) set on any change of the matching level, rising or falling. Each flag stays set until a read.
- R4: The ring change flag at bit 2 sets only when the ring pin goes from low to high, which marks the end of ringing. The start of ringing leaves the flag clear.
- R5: `irq` is high exactly while some change flag is set and `msr_irq_en` is 1.
- R6: While reset is applied, and after it, the status word reads with all four change flags at 0 and `irq` at 0 when the pins are idle (high).
- R7: A cycle with `rd_stb` high clears all four change flags at the next rising edge. A change detected in that same cycle still sets its flag.
- R8: A pin change shows in the status word at the third rising clock edge after it is applied. A loopback source or mode change shows at the first rising edge.
- R9: Entering or leaving loopback, and changes of the loopback source bits, set change flags by the same rules as pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| pin_ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| pin_cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback mode select |
| lb_ctrl | input | 4 | Loopback sources: [0] terminal-ready, [1] request-to-send, [2] ring source, [3] carrier source |
| rd_stb | input | 1 | Host read strobe for the status word |
| msr_irq_en | input | 1 | Modem status interrupt enable |
| status | output | 8 | [7:4] line levels CD, RI, DSR, CTS; [3:0] change flags CD, RI, DSR, CTS |
| irq | output | 1 | Modem status interrupt request |

## Verification
A stale previous-level register would show as a change flag set with no stimulus, or a real edge missed, within one cycle of the level reaching the detector. A wrong loopback mapping puts the wrong upper status bit high on the first edge after the source bits change. A wrong ring edge polarity flags the start of ringing instead of the end. A read-clear that overrides a new edge loses a flag, and that loss is visible in the status word one cycle after the read. An extra or missing synchronizer stage moves the pin-to-status delay off the third edge.

// File: rtl/msd_pkg.sv
package msd_pkg;

    localparam int NLINES = 4;

    // loopback source bit positions
    localparam int LB_DTR = 0;
    localparam int LB_RTS = 1;
    localparam int LB_RNG = 2;
    localparam int LB_CAR = 3;

    // line order matches status bit order inside each nibble
    typedef struct packed {
        logic cd;   // nibble bit 3
        logic ri;   // nibble bit 2
        logic dsr;  // nibble bit 1
        logic cts;  // nibble bit 0
    } line_t;

    typedef struct packed {
        line_t lvl;    // status[7:4]
        line_t delta;  // status[3:0]
    } status_t;

    // pins_n packed as {cd, ri, dsr, cts}
    function automatic line_t lines_from_pins(input logic [NLINES-1:0] pins_n);
        line_t l;
        l = line_t'(~pins_n);
        return l;
    endfunction

    function automatic line_t lines_from_loop(input logic [NLINES-1:0] ctrl);
        line_t l;
        l.cts = ctrl[LB_RTS];
        l.dsr = ctrl[LB_DTR];
        l.ri  = ctrl[LB_RNG];
        l.cd  = ctrl[LB_CAR];
        return l;
    endfunction

    // ring flags only its trailing edge (asserted -> released)
    function automatic line_t line_edges(input line_t prev, input line_t cur);
        line_t e;
        e.cts = prev.cts ^ cur.cts;
        e.dsr = prev.dsr ^ cur.dsr;
        e.cd  = prev.cd  ^ cur.cd;
        e.ri  = prev.ri  & ~cur.ri;
        return e;
    endfunction

endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

    // R8
    sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (chain[0] == $past(d_async)));
endmodule

// File: rtl/msd_source_sel.sv
module msd_source_sel
    import msd_pkg::*;
(
    input  logic [NLINES-1:0] pins_n_sync,
    input  logic              loop_en,
    input  logic [NLINES-1:0] lb_ctrl,
    output line_t             lvl
);
    line_t from_pin;
    line_t from_lb;

    always_comb begin
        from_pin = lines_from_pins(pins_n_sync);
        from_lb  = lines_from_loop(lb_ctrl);
        lvl      = loop_en ? from_lb : from_pin;
    end
endmodule

// File: rtl/msd_delta.sv
module msd_delta
    import msd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t lvl,
    input  logic  rd_stb,
    output line_t lvl_q,
    output line_t flags
);
    line_t edges;

    always_comb edges = line_edges(lvl_q, lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            flags <= '0;
        end else begin
            lvl_q <= lvl;
            flags <= (rd_stb ? line_t'('0) : flags) | edges;
        end
    end

    // R7
    delta_rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && (edges == '0)) |=> (flags == '0));

    // R3
    delta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((flags & $past(flags)) == $past(flags)));

    // R4
    ring_trailing_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !flags.ri && !(lvl_q.ri && !lvl.ri)) |=> !flags.ri);
endmodule

// File: rtl/msd_modem_status.sv
module msd_modem_status
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_cts_n,
    input  logic       pin_dsr_n,
    input  logic       pin_ri_n,
    input  logic       pin_cd_n,
    input  logic       loop_en,
    input  logic [3:0] lb_ctrl,
    input  logic       rd_stb,
    input  logic       msr_irq_en,
    output logic [7:0] status,
    output logic       irq
);
    logic [NLINES-1:0] pins_n_sync;
    line_t             lvl;
    line_t             lvl_q;
    line_t             flags;
    status_t           st;

    msd_sync #(
        .W      (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NLINES{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async({pin_cd_n, pin_ri_n, pin_dsr_n, pin_cts_n}),
        .q_sync (pins_n_sync)
    );

    msd_source_sel u_sel (
        .pins_n_sync(pins_n_sync),
        .loop_en    (loop_en),
        .lb_ctrl    (lb_ctrl),
        .lvl        (lvl)
    );

    msd_delta u_delta (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl),
        .rd_stb(rd_stb),
        .lvl_q (lvl_q),
        .flags (flags)
    );

    always_comb begin
        st.lvl   = lvl_q;
        st.delta = flags;
        status   = st;
        irq      = msr_irq_en & (|flags);
    end

    // R2
    loop_cts_map_chk: assert property (@(posedge clk) disable iff (rst)
        loop_en |=> (status[4] == $past(lb_ctrl[LB_RTS]) && status[5] == $past(lb_ctrl[LB_DTR])));

    // R5
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (status[3:0] == 4'b0 || !msr_irq_en) |-> !irq);
endmodule

// File: tb/sim_msd_modem_status.sv
`timescale 1ns/1ps
module sim_msd_modem_status;
    logic       clk = 1'b0;
    logic       rst;
    logic       pin_cts_n, pin_dsr_n, pin_ri_n, pin_cd_n;
    logic       loop_en;
    logic [3:0] lb_ctrl;
    logic       rd_stb;
    logic       msr_irq_en;
    logic [7:0] status;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    msd_modem_status u0 (
        .clk(clk), .rst(rst),
        .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
        .pin_ri_n(pin_ri_n), .pin_cd_n(pin_cd_n),
        .loop_en(loop_en), .lb_ctrl(lb_ctrl),
        .rd_stb(rd_stb), .msr_irq_en(msr_irq_en),
        .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
        end
    endtask

    // wait n rising edges, then sample at the falling edge
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // one read cycle; returns the word seen during the read
    task automatic do_read(output logic [7:0] seen);
        @(negedge clk);
        rd_stb = 1'b1;
        seen   = status;
        @(posedge clk);
        #1 rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        pin_cts_n = 1; pin_dsr_n = 1; pin_ri_n = 1; pin_cd_n = 1;
        loop_en = 0; lb_ctrl = 4'b0; rd_stb = 0; msr_irq_en = 1;
        edges(4);
        chk("R6 status in reset", status, 8'h00);
        chk("R6 irq in reset", {7'b0, irq}, 8'h00);
        rst = 1'b0;
        edges(4);
        chk("R6 status after reset", status, 8'h00);
        chk("R6 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_normal;
        logic [7:0] s;
        @(negedge clk);
        pin_cts_n = 0;
        edges(2);
        chk("R8 not yet after two edges", status, 8'h00);
        edges(1);
        chk("R1 R3 R8 cts asserted", status, 8'b0001_0001);
        chk("R5 irq enabled", {7'b0, irq}, 8'h01);
        do_read(s);
        chk("R7 read sees word", s, 8'b0001_0001);
        chk("R7 flags cleared", status, 8'b0001_0000);
        chk("R5 irq drops", {7'b0, irq}, 8'h00);
        pin_dsr_n = 0; pin_cd_n = 0;
        edges(3);
        chk("R1 R3 dsr cd asserted", status, 8'b1011_1010);
        do_read(s);
        pin_cts_n = 1; pin_dsr_n = 1; pin_cd_n = 1;
        edges(3);
        chk("R3 release edges flagged", status, 8'b0000_1011);
        do_read(s);
        chk("R7 cleared again", status, 8'h00);
    endtask

    task automatic t_ring;
        logic [7:0] s;
        msr_irq_en = 0;
        @(negedge clk);
        pin_ri_n = 0;
        edges(3);
        chk("R4 ring start not flagged", status, 8'b0100_0000);
        pin_ri_n = 1;
        edges(3);
        chk("R4 ring end flagged", status, 8'b0000_0100);
        chk("R5 irq masked", {7'b0, irq}, 8'h00);
        msr_irq_en = 1;
        #1 chk("R5 irq unmasked", {7'b0, irq}, 8'h01);
        do_read(s);
    endtask

    task automatic t_loop;
        logic [7:0] s;
        @(negedge clk);
        lb_ctrl = 4'b0000; loop_en = 1;
        edges(1);
        chk("R9 idle loop entry no flags", status, 8'h00);
        lb_ctrl = 4'b0010;
        edges(1);
        chk("R2 R8 rts feeds cts", status, 8'b0001_0001);
        lb_ctrl = 4'b0001;
        edges(1);
        chk("R2 R9 dtr feeds dsr", status, 8'b0010_0011);
        lb_ctrl = 4'b1100;
        edges(1);
        chk("R2 aux bits feed ri cd", status, 8'b1100_1011);
        do_read(s);
        pin_cts_n = 0;
        edges(4);
        chk("R2 pins ignored in loopback", status, 8'b1100_0000);
        loop_en = 0;
        edges(1);
        chk("R9 loop exit flagged", status, 8'b0001_1101);
        do_read(s);
        pin_cts_n = 1;
        edges(3);
        do_read(s);
        chk("R1 back to idle", status, 8'h00);
    endtask

    task automatic t_same_cycle;
        logic [7:0] s;
        @(negedge clk);
        lb_ctrl = 4'b0000; loop_en = 1;
        edges(1);
        do_read(s);
        @(negedge clk);
        lb_ctrl = 4'b0010;
        rd_stb  = 1'b1;
        @(posedge clk);
        #1 rd_stb = 1'b0;
        @(negedge clk);
        chk("R7 edge during read kept", status, 8'b0001_0001);
        loop_en = 0; lb_ctrl = 4'b0;
        edges(1);
        do_read(s);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_ring();
        t_loop();
        t_same_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule